// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block holds a 64-bit signed accumulator as two 32-bit registers, an upper half and a lower half. Each start strobe multiplies two signed operands and adds the product into the accumulator. The unit has two product widths. Long mode multiplies the full 32-bit operands. Word mode multiplies only the low 16 bits of each operand. The updated halves are visible, with a done pulse, on the cycle after the start.

A saturation input selects how the sum is limited when it is stored. In long mode the upper half is reduced to a 48-bit-style pattern that follows the sign of the sum. In word mode the lower half is clamped to the 32-bit signed range, and the upper half is set to one whenever a clamp happens. Software-style load ports write either half directly, and a synchronous clear zeroes both halves.

The unit has no back-pressure: it accepts a start on every cycle, so no ready signal exists. A write to either half on the same cycle as a start is applied before the product is added. Clear overrides both the writes and the start.

Top module: `mac_sat_unit`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted, both accumulator halves read zero and done_o is low.
- R2: In long mode (mode_i = 0) the full 32-bit operands are sign-extended and multiplied. The 64-bit product is added to the accumulator {acc_hi_o, acc_lo_o}, with the upper half in bits 63:32. With sat_i low, the sum is stored modulo 2^64.
- R3: In word mode (mode_i = 1) only bits 15:0 of each operand enter the product, as signed values. Bits 31:16 have no effect on the result.
- R4: In long mode with sat_i high, acc_lo_o receives bits 31:0 of the sum. If the sum is negative (bit 63 set), acc_hi_o receives bits 63:32 of the sum ORed with 0xFFFF0000. Otherwise acc_hi_o receives bits 63:32 ANDed with 0x00007FFF.
- R5: In word mode with sat_i high, a sum below -2^31 stores 0x80000000 in acc_lo_o and 1 in acc_hi_o. A sum above 2^31-1 stores 0x7FFFFFFF in acc_lo_o and 1 in acc_hi_o. A sum inside the range is stored unchanged.
- R6: done_o is high for exactly the one cycle after an accepted start, and the new accumulator value is on the outputs in that same cycle.
- R7: hi_wr_i and lo_wr_i load their data into the matching half on the next edge. On a start cycle the loaded values are the ones the product is added to.
- R8: clr_i zeroes both halves on the next edge and overrides start and both writes; no done pulse follows a start that coincides with clr_i.
- R9: With no start, write or clear, both halves hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start one multiply-accumulate |
| mode_i | input | 1 | 0 = long (32x32), 1 = word (16x16) |
| sat_i | input | 1 | Saturating write-back when high |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| clr_i | input | 1 | Synchronous clear of both halves |
| hi_wr_i | input | 1 | Load enable for the upper half |
| hi_wdata_i | input | 32 | Upper half load data |
| lo_wr_i | input | 1 | Load enable for the lower half |
| lo_wdata_i | input | 32 | Lower half load data |
| acc_hi_o | output | 32 | Accumulator bits 63:32 |
| acc_lo_o | output | 32 | Accumulator bits 31:0 |
| done_o | output | 1 | One-cycle pulse after a start |

## Verification
Every result of this block is due one register stage after its stimulus: a start, write or clear presented before a rising edge shows on acc_hi_o, acc_lo_o and done_o right after that edge. The bench drives all inputs on the falling edge and samples on the following falling edge, so each check reads the state exactly one edge after its stimulus. It then samples one more falling edge to confirm that done_o has dropped and the value has held. Preloads use the same-cycle write path, so every vector also checks the write-then-accumulate ordering.

// File: rtl/mac_sat_pkg.sv
package mac_sat_pkg;

  typedef enum logic {
    MODE_LONG = 1'b0,
    MODE_WORD = 1'b1
  } mac_mode_e;

  localparam int unsigned DEF_DATA_W    = 32;
  localparam int unsigned DEF_NARROW_W  = 16;
  localparam int unsigned DEF_LONG_KEEP = 15;

endpackage

// File: rtl/mac_prod_gen.sv
module mac_prod_gen
  import mac_sat_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned NARROW_W = DEF_NARROW_W,
  localparam int unsigned ACC_W   = 2 * DATA_W
) (
  input  mac_mode_e          mode,
  input  logic [DATA_W-1:0]  opa,
  input  logic [DATA_W-1:0]  opb,
  output logic [ACC_W-1:0]   prod
);

  logic signed [ACC_W-1:0] wide_a, wide_b, wide_p;
  logic signed [ACC_W-1:0] narrow_a, narrow_b, narrow_p;

  // full-width sign extension to the accumulator width
  assign wide_a = $signed({{DATA_W{opa[DATA_W-1]}}, opa});
  assign wide_b = $signed({{DATA_W{opb[DATA_W-1]}}, opb});
  assign wide_p = wide_a * wide_b;

  generate
    if (NARROW_W < DATA_W) begin : g_narrow
      assign narrow_a = $signed({{(ACC_W-NARROW_W){opa[NARROW_W-1]}}, opa[NARROW_W-1:0]});
      assign narrow_b = $signed({{(ACC_W-NARROW_W){opb[NARROW_W-1]}}, opb[NARROW_W-1:0]});
    end else begin : g_narrow_full
      assign narrow_a = wide_a;
      assign narrow_b = wide_b;
    end
  endgenerate

  assign narrow_p = narrow_a * narrow_b;

  always_comb begin
    if (mode == MODE_WORD) prod = narrow_p;
    else                   prod = wide_p;
  end

endmodule

// File: rtl/mac_sum_sat.sv
module mac_sum_sat
  import mac_sat_pkg::*;
#(
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned LONG_KEEP = DEF_LONG_KEEP,
  localparam int unsigned ACC_W    = 2 * DATA_W
) (
  input  mac_mode_e         mode,
  input  logic              sat,
  input  logic [DATA_W-1:0] base_hi,
  input  logic [DATA_W-1:0] base_lo,
  input  logic [ACC_W-1:0]  prod,
  output logic [DATA_W-1:0] res_hi,
  output logic [DATA_W-1:0] res_lo
);

  // upper-half masks for long-mode saturation
  localparam logic [DATA_W-1:0] KEEP_MASK = (DATA_W)'((64'd1 << LONG_KEEP) - 64'd1);
  localparam logic [DATA_W-1:0] NEG_FILL  = ~(DATA_W)'((64'd1 << (LONG_KEEP + 1)) - 64'd1);
  localparam logic [DATA_W-1:0] POS_LIM   = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_LIM   = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] CLAMP_HI  = (DATA_W)'(1);

  logic [ACC_W-1:0]    sum;
  logic [DATA_W:0]     sign_run;
  logic                fits_low;
  logic                sum_neg;

  assign sum      = {base_hi, base_lo} + prod;
  assign sum_neg  = sum[ACC_W-1];
  // the sum fits a signed low half when bits ACC_W-1 .. DATA_W-1 all agree
  assign sign_run = sum[ACC_W-1:DATA_W-1];
  assign fits_low = (&sign_run) | ~(|sign_run);

  always_comb begin
    res_hi = sum[ACC_W-1:DATA_W];
    res_lo = sum[DATA_W-1:0];
    if (sat) begin
      if (mode == MODE_LONG) begin
        if (sum_neg) res_hi = sum[ACC_W-1:DATA_W] | NEG_FILL;
        else         res_hi = sum[ACC_W-1:DATA_W] & KEEP_MASK;
      end else if (!fits_low) begin
        res_hi = CLAMP_HI;
        res_lo = sum_neg ? NEG_LIM : POS_LIM;
      end
    end
  end

endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
  import mac_sat_pkg::*;
#(
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned NARROW_W  = DEF_NARROW_W,
  parameter int unsigned LONG_KEEP = DEF_LONG_KEEP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              sat_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              clr_i,
  input  logic              hi_wr_i,
  input  logic [DATA_W-1:0] hi_wdata_i,
  input  logic              lo_wr_i,
  input  logic [DATA_W-1:0] lo_wdata_i,
  output logic [DATA_W-1:0] acc_hi_o,
  output logic [DATA_W-1:0] acc_lo_o,
  output logic              done_o
);

  localparam int unsigned ACC_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] ONE_W = (DATA_W)'(1);
  localparam logic [DATA_W-1:0] ALL_W = '1;

  mac_mode_e         mode;
  logic [DATA_W-1:0] hi_q, lo_q;
  logic [DATA_W-1:0] base_hi, base_lo;
  logic [DATA_W-1:0] res_hi, res_lo;
  logic [ACC_W-1:0]  prod;
  logic              done_q;

  assign mode = mac_mode_e'(mode_i);

  // loads on a start cycle are applied before the product is added
  assign base_hi = hi_wr_i ? hi_wdata_i : hi_q;
  assign base_lo = lo_wr_i ? lo_wdata_i : lo_q;

  mac_prod_gen #(
    .DATA_W  (DATA_W),
    .NARROW_W(NARROW_W)
  ) u_prod (
    .mode(mode),
    .opa (opa_i),
    .opb (opb_i),
    .prod(prod)
  );

  mac_sum_sat #(
    .DATA_W   (DATA_W),
    .LONG_KEEP(LONG_KEEP)
  ) u_sum (
    .mode   (mode),
    .sat    (sat_i),
    .base_hi(base_hi),
    .base_lo(base_lo),
    .prod   (prod),
    .res_hi (res_hi),
    .res_lo (res_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      hi_q   <= '0;
      lo_q   <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      hi_q   <= res_hi;
      lo_q   <= res_lo;
      done_q <= 1'b1;
    end else begin
      hi_q   <= base_hi;
      lo_q   <= base_lo;
      done_q <= 1'b0;
    end
  end

  assign acc_hi_o = hi_q;
  assign acc_lo_o = lo_q;
  assign done_o   = done_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n) clr_i |=> (acc_hi_o == '0 && acc_lo_o == '0 && !done_o)); // R8
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !clr_i) |=> done_o); // R6
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n) (!start_i || clr_i) |=> !done_o); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!start_i && !clr_i && !hi_wr_i && !lo_wr_i) |=> ($stable(acc_hi_o) && $stable(acc_lo_o))); // R9
  AST_LONG_SAT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !clr_i && !mode_i && sat_i) |=> ((acc_hi_o[DATA_W-1:LONG_KEEP+1] == '1) || (acc_hi_o[DATA_W-1:LONG_KEEP] == '0))); // R4
  AST_WORD_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !clr_i && mode_i && sat_i) |=> (acc_hi_o == '0 || acc_hi_o == ONE_W || acc_hi_o == ALL_W)); // R5
  AST_LOAD_HI: assert property (@(posedge clk) disable iff (!rst_n) (hi_wr_i && !start_i && !clr_i) |=> (acc_hi_o == $past(hi_wdata_i))); // R7

endmodule

// File: tb/mac_sat_unit_bench.sv
module mac_sat_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NVEC       = 12;
  localparam int VEC_W      = 194;

  // {word_mode, sat, hi_load, lo_load, opa, opb, exp_hi, exp_lo}
  localparam logic [VEC_W-1:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 32'h00000000, 32'h00000000, 32'h00000003, 32'h00000005, 32'h00000000, 32'h0000000F}, // R2
    {1'b0, 1'b0, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'h00000002, 32'hFFFFFFFF, 32'hFFFFFFFE}, // R2
    {1'b0, 1'b0, 32'h00000000, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 32'h00000001, 32'h00000000}, // R2 carry
    {1'b0, 1'b0, 32'h00000000, 32'h00000000, 32'h80000000, 32'h80000000, 32'h40000000, 32'h00000000}, // R2
    {1'b1, 1'b0, 32'h00000000, 32'h00000000, 32'h1234FFFF, 32'hABCD0003, 32'hFFFFFFFF, 32'hFFFFFFFD}, // R3
    {1'b1, 1'b0, 32'h00000000, 32'h00000000, 32'h00008000, 32'h00008000, 32'h00000000, 32'h40000000}, // R3
    {1'b0, 1'b1, 32'h00012345, 32'h00000000, 32'hFFFFFFFF, 32'h00000001, 32'h00002344, 32'hFFFFFFFF}, // R4
    {1'b0, 1'b1, 32'h80001234, 32'h00000000, 32'h00000001, 32'h00000001, 32'hFFFF1234, 32'h00000001}, // R4
    {1'b1, 1'b1, 32'h00000000, 32'h7FFFFFFF, 32'h00000001, 32'h00000001, 32'h00000001, 32'h7FFFFFFF}, // R5
    {1'b1, 1'b1, 32'hFFFFFFFF, 32'h80000000, 32'h0000FFFF, 32'h00000001, 32'h00000001, 32'h80000000}, // R5
    {1'b1, 1'b1, 32'h00000000, 32'h00000010, 32'h00000002, 32'h00000003, 32'h00000000, 32'h00000016}, // R5
    {1'b1, 1'b1, 32'hFFFFFFFF, 32'h80000000, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'h80000000}  // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, mode_i = 1'b0, sat_i = 1'b0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic        clr_i = 1'b0, hi_wr_i = 1'b0, lo_wr_i = 1'b0;
  logic [31:0] hi_wdata_i = '0, lo_wdata_i = '0;
  logic [31:0] acc_hi_o, acc_lo_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_sat_unit u_mac_sat_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .sat_i(sat_i),
    .opa_i(opa_i), .opb_i(opb_i), .clr_i(clr_i), .hi_wr_i(hi_wr_i),
    .hi_wdata_i(hi_wdata_i), .lo_wr_i(lo_wr_i), .lo_wdata_i(lo_wdata_i),
    .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    start_i = 1'b0; clr_i = 1'b0; hi_wr_i = 1'b0; lo_wr_i = 1'b0;
  endtask

  task automatic run_op(input logic wm, input logic st, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    idle_inputs();
    start_i = 1'b1; mode_i = wm; sat_i = st; opa_i = a; opb_i = b;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R6 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset state, R1
    repeat (3) @(negedge clk);
    chk("R1 hi in reset", acc_hi_o, 32'h0);
    chk("R1 lo in reset", acc_lo_o, 32'h0);
    chk("R1 done in reset", {31'b0, done_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: preload both halves on the start cycle (R7 ordering)
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      start_i    = 1'b1;
      mode_i     = VECS[i][193];
      sat_i      = VECS[i][192];
      hi_wr_i    = 1'b1; hi_wdata_i = VECS[i][191:160];
      lo_wr_i    = 1'b1; lo_wdata_i = VECS[i][159:128];
      opa_i      = VECS[i][127:96];
      opb_i      = VECS[i][95:64];
      @(negedge clk);
      idle_inputs();
      chk($sformatf("R2/R7 vec%0d hi", i), acc_hi_o, VECS[i][63:32]);
      chk($sformatf("R2/R7 vec%0d lo", i), acc_lo_o, VECS[i][31:0]);
      chk($sformatf("R6 vec%0d done", i), {31'b0, done_o}, 32'h1);
      @(negedge clk);
      chk($sformatf("R6 vec%0d done drops", i), {31'b0, done_o}, 32'h0);
      chk($sformatf("R9 vec%0d hold lo", i), acc_lo_o, VECS[i][31:0]);
    end

    // clear, then two accumulates in a row: 6 + 6 = 12 (R2, R8)
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); idle_inputs();
    chk("R8 clear hi", acc_hi_o, 32'h0);
    chk("R8 clear lo", acc_lo_o, 32'h0);
    run_op(1'b0, 1'b0, 32'd2, 32'd3);
    run_op(1'b0, 1'b0, 32'd2, 32'd3);
    chk("R2 accumulate twice", acc_lo_o, 32'd12);

    // word mode ignores upper operand bits: -1 * 1 from 0x7FFF_FFFF and 0x5555_0001 (R3)
    run_op(1'b1, 1'b0, 32'h7FFFFFFF, 32'h55550001);
    chk("R3 upper bits ignored lo", acc_lo_o, 32'd11);
    chk("R3 upper bits ignored hi", acc_hi_o, 32'h0);

    // load only the lower half; upper unchanged (R7)
    @(negedge clk); lo_wr_i = 1'b1; lo_wdata_i = 32'hCAFE0001;
    @(negedge clk); idle_inputs();
    chk("R7 lo load", acc_lo_o, 32'hCAFE0001);
    chk("R7 hi untouched", acc_hi_o, 32'h0);
    @(negedge clk); hi_wr_i = 1'b1; hi_wdata_i = 32'h00000077;
    @(negedge clk); idle_inputs();
    chk("R7 hi load", acc_hi_o, 32'h00000077);

    // idle hold (R9)
    repeat (3) @(negedge clk);
    chk("R9 idle hi", acc_hi_o, 32'h00000077);
    chk("R9 idle lo", acc_lo_o, 32'hCAFE0001);

    // clear beats start and writes (R8)
    @(negedge clk);
    clr_i = 1'b1; start_i = 1'b1; mode_i = 1'b0; sat_i = 1'b0; opa_i = 32'd9; opb_i = 32'd9;
    hi_wr_i = 1'b1; hi_wdata_i = 32'h1; lo_wr_i = 1'b1; lo_wdata_i = 32'h1;
    @(negedge clk); idle_inputs();
    chk("R8 clear over start hi", acc_hi_o, 32'h0);
    chk("R8 clear over start lo", acc_lo_o, 32'h0);
    chk("R8 no done with clear", {31'b0, done_o}, 32'h0);

    // asynchronous reset mid-run (R1)
    run_op(1'b0, 1'b0, 32'd5, 32'd5);
    #1 rst_n = 1'b0;
    #1;
    chk("R1 async reset lo", acc_lo_o, 32'h0);
    chk("R1 async reset done", {31'b0, done_o}, 32'h0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule